// File: doc/BRIEF.md
# Window Watchdog Reset Supervisor

This block produces the active-low reset for a microprocessor. It also controls the on/off request of the regulator that powers that processor. It watches three things: a digital "output in regulation" flag, an enable input, and a watchdog kick line from the processor. After power-up, the processor is held in reset until the supply has been good for a full power-on delay. While running, the processor must deliver rising kick edges whose spacing lies inside a window. An edge that comes too early is a fault. A gap that runs too long is also a fault.

On a watchdog fault with enable high, the regulator stays on. The reset line becomes a square pulse train and keeps running until one kick period inside the window is seen; the reset then stays released. On a watchdog fault with enable low, the regulator request drops and the block enters sleep. In sleep, only the enable input is watched, and raising enable starts a fresh power-on sequence. A supply dip that lasts longer than a short glitch filter forces reset at once and restarts the power-on delay.

All timing except the glitch filter is counted in one base tick, taken from the clock by a prescaler. The window limits and the power-on delay are derived from the pulse width, so they all scale together. The power-on delay is 47.5 pulse widths. All inputs are expected to be synchronous, except the kick line, which gets its own two-flop synchronizer. No data stream passes through the block, so every pin is a plain level signal with no handshake.

Top module: `wdr_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0, `reg_on` is 1 and `sleep` is 0.
- R2: With `in_reg` high from the start, `rst_out_n` rises on the clock edge after the power-on counter reaches POR_DLY = PULSE_W*95/2 ticks. With TICK_DIV=1 this is clock POR_DLY+1 after reset release.
- R3: A kick period shorter than WIN_LO = PULSE_W*LO_MULT ticks, measured between synchronized rising edges of `wdi`, is a fault.
- R4: No rising `wdi` edge for more than WIN_HI = PULSE_W*HI_MULT ticks is a fault.
- R5: During a fault with `enable` high, `reg_on` stays 1 and `rst_out_n` toggles. It is low for PULSE_W ticks, then high for PULSE_W ticks, and repeats, starting low.
- R6: In the pulse train, one kick period within [WIN_LO, WIN_HI] ends the train, and `rst_out_n` then stays high.
- R7: `in_reg` low for UV_FILT consecutive clocks drives `rst_out_n` low on the next clock. A shorter dip has no effect.
- R8: After a supply dip, `rst_out_n` stays low until `in_reg` has been high for a full POR_DLY ticks again.
- R9: A fault with `enable` low drives `reg_on` to 0, `sleep` to 1 and `rst_out_n` to 0.
- R10: In sleep, raising `enable` clears `sleep` and sets `reg_on` on the next clock. A full power-on delay then follows before reset releases.
- R11: With valid kicks, driving `enable` low has no effect on `rst_out_n` or `reg_on`.
- R12: Kicks spaced within the window keep `rst_out_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| enable | input | 1 | Keep-alive; high keeps the regulator on |
| in_reg | input | 1 | High when the supplied output is in regulation |
| wdi | input | 1 | Watchdog kick line from the processor (asynchronous) |
| rst_out_n | output | 1 | Registered active-low processor reset |
| reg_on | output | 1 | Regulator enable request |
| sleep | output | 1 | High while in the low-power sleep state |

## Verification
The bench checks the exact release clock after power-up, after a supply dip and after waking from sleep. A power-on counter that is off by one, or that is not cleared by the dip, shows up as a release one clock early or late. Supply dips of UV_FILT-1 clocks and of UV_FILT clocks separate a glitch filter that is too loose from one that is too strict. Both kinds of fault are driven: kicks that are too fast and kicks that stop. The pulse train is compared clock by clock, so a wrong phase length or a train that starts high is caught. Recovery and the enable-low cases catch a design that never leaves the train, that sleeps while enable is high, or that turns the regulator off just because enable is low.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2,
    ST_SLEEP = 2'd3
  } sup_state_e;
endpackage

// File: rtl/wdr_tick_gen.sv
module wdr_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(TICK_DIV);
      localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
      a_r2_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    end
  endgenerate
endmodule

// File: rtl/wdr_uv_filter.sv
module wdr_uv_filter #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_reg,
  output logic uv
);
  localparam int W = $clog2(FILT + 1);
  localparam logic [W-1:0] FULL = W'(FILT);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (in_reg)      cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end
  assign uv = (cnt == FULL);

  a_r7_good_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_reg |=> !uv);
  a_r7_filter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
endmodule

// File: rtl/wdr_wdi_monitor.sv
module wdr_wdi_monitor #(
  parameter int WIN_LO = 8,
  parameter int WIN_HI = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic wdi,
  output logic good,
  output logic bad
);
  localparam int CW = $clog2(WIN_HI + 2);
  localparam logic [CW-1:0] LO_C  = CW'(WIN_LO);
  localparam logic [CW-1:0] HI_C  = CW'(WIN_HI);
  localparam logic [CW-1:0] OVF_C = CW'(WIN_HI + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          rise;
  logic          in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wdi};
  end
  assign rise   = sync_q[1] & ~sync_q[2];
  assign in_win = (cnt >= LO_C) && (cnt <= HI_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (rise) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (tick && cnt != OVF_C) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign good = !clr && rise && armed && in_win;
  assign bad  = !clr && ((rise && armed && !in_win) ||
                         (tick && !rise && cnt == HI_C));

  a_r4_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVF_C);
  a_r6_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(good && bad));
  a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !armed));
endmodule

// File: rtl/wdr_supervisor.sv
module wdr_supervisor
  import wdr_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int PULSE_W  = 2,
  parameter int LO_MULT  = 4,
  parameter int HI_MULT  = 12,
  parameter int UV_FILT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic in_reg,
  input  logic wdi,
  output logic rst_out_n,
  output logic reg_on,
  output logic sleep
);
  localparam int WIN_LO  = PULSE_W * LO_MULT;
  localparam int WIN_HI  = PULSE_W * HI_MULT;
  localparam int POR_DLY = (PULSE_W * 95) / 2;
  localparam int PORW    = $clog2(POR_DLY + 1);
  localparam int PW      = $clog2(PULSE_W + 1);
  localparam logic [PORW-1:0] POR_C    = PORW'(POR_DLY);
  localparam logic [PW-1:0]   PUL_LAST = PW'(PULSE_W - 1);

  sup_state_e      state_q, nxt;
  logic [PORW-1:0] por_cnt;
  logic [PW-1:0]   pul_cnt, pul_d;
  logic            phase_q, phase_d;
  logic            tick, uv, good, bad, mon_clr, por_done;

  wdr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  wdr_uv_filter #(.FILT(UV_FILT)) u_uv (
    .clk(clk), .rst_n(rst_n), .in_reg(in_reg), .uv(uv));

  assign mon_clr = (state_q == ST_POR) || (state_q == ST_SLEEP);

  wdr_wdi_monitor #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(mon_clr), .wdi(wdi),
    .good(good), .bad(bad));

  assign por_done = (por_cnt == POR_C);

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_POR:   if (!uv && in_reg && por_done) nxt = ST_RUN;
      ST_RUN:   if (uv) nxt = ST_POR;
                else if (bad) nxt = enable ? ST_FAULT : ST_SLEEP;
      ST_FAULT: if (uv) nxt = ST_POR;
                else if (!enable) nxt = ST_SLEEP;
                else if (good) nxt = ST_RUN;
      ST_SLEEP: if (enable) nxt = ST_POR;
      default:  nxt = ST_POR;
    endcase
  end

  always_comb begin
    pul_d   = pul_cnt;
    phase_d = phase_q;
    if (!(state_q == ST_FAULT && nxt == ST_FAULT)) begin
      pul_d   = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      if (pul_cnt == PUL_LAST) begin
        pul_d   = '0;
        phase_d = ~phase_q;
      end else begin
        pul_d = pul_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_POR;
      por_cnt   <= '0;
      pul_cnt   <= '0;
      phase_q   <= 1'b0;
      rst_out_n <= 1'b0;
      reg_on    <= 1'b1;
      sleep     <= 1'b0;
    end else begin
      state_q <= nxt;
      pul_cnt <= pul_d;
      phase_q <= phase_d;
      if (state_q != ST_POR || !in_reg) por_cnt <= '0;
      else if (tick && !por_done)       por_cnt <= por_cnt + 1'b1;
      rst_out_n <= (nxt == ST_RUN) || (nxt == ST_FAULT && phase_d);
      reg_on    <= (nxt != ST_SLEEP);
      sleep     <= (nxt == ST_SLEEP);
    end
  end

  a_r7_dip_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && state_q != ST_SLEEP) |=> !rst_out_n);
  a_r2_hold_until_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR && !por_done) |=> !rst_out_n);
  a_r10_wake_to_por: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && enable) |=> (state_q == ST_POR && reg_on && !sleep));
  a_r5_enable_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> reg_on);
  a_r9_sleep_is_dark: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!reg_on && !rst_out_n));
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pul_cnt <= PUL_LAST);
endmodule

// File: tb/wdr_supervisor_bench.sv
`timescale 1ns/1ps
module wdr_supervisor_bench;
  localparam int PULSE_W = 2;
  localparam int POR_DLY = (PULSE_W * 95) / 2;
  localparam int UV_FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic in_reg = 1'b1;
  logic wdi = 1'b0;
  logic rst_out_n, reg_on, sleep;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  kick_en = 1'b0;
  int  kick_per = 16;
  int  ph = 0;
  bit  done = 1'b0;

  typedef struct {
    int    at;
    int    sig;   // 0 rst_out_n, 1 reg_on, 2 sleep
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdr_supervisor #(.TICK_DIV(1), .PULSE_W(PULSE_W), .LO_MULT(4), .HI_MULT(12),
                   .UV_FILT(UV_FILT)) u_wdr_supervisor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_reg(in_reg), .wdi(wdi),
    .rst_out_n(rst_out_n), .reg_on(reg_on), .sleep(sleep));

  task automatic rep(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int at, input int sig, input logic val, input string req);
    exp_t it;
    int i = 0;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    while (i < q.size() && q[i].at <= at) i++;
    q.insert(i, it);
  endtask

  // monitor: pops scoreboard items when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t it;
      logic act;
      it = q.pop_front();
      act = (it.sig == 0) ? rst_out_n : (it.sig == 1) ? reg_on : sleep;
      rep(it.at == cyc && act === it.val, it.req, int'(act), int'(it.val));
    end
  end

  // kick generator
  always @(negedge clk) begin
    if (!kick_en) begin
      wdi <= 1'b0;
      ph  <= 0;
    end else begin
      wdi <= (ph < 2);
      ph  <= (ph + 1) % kick_per;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall(input int lim, input string req);
    for (int i = 0; i < lim && rst_out_n; i++) @(negedge clk);
    rep(rst_out_n == 1'b0, req, int'(rst_out_n), 0);
  endtask

  task automatic wait_recover(input string req);
    int hi_run = 0;
    for (int i = 0; i < 120 && hi_run < 3; i++) begin
      @(negedge clk);
      hi_run = rst_out_n ? hi_run + 1 : 0;
    end
    rep(hi_run >= 3, req, hi_run, 3);
    expect_at(cyc + 10, 0, 1'b1, "R6 stays released");
    expect_at(cyc + 40, 0, 1'b1, "R6 stays released");
    wait_cyc(41);
  endtask

  initial begin : driver
    int m;
    int f;
    wait_cyc(3);
    rep(rst_out_n == 1'b0, "R1 reset rst_out_n", int'(rst_out_n), 0);
    rep(reg_on == 1'b1, "R1 reset reg_on", int'(reg_on), 1);
    rep(sleep == 1'b0, "R1 reset sleep", int'(sleep), 0);

    // R2: power-on delay
    rst_n = 1'b1;
    m = cyc;
    kick_en = 1'b1;
    expect_at(m + POR_DLY, 0, 1'b0, "R2 held before delay");
    expect_at(m + POR_DLY + 1, 0, 1'b1, "R2 released after delay");
    wait_cyc(POR_DLY + 5);

    // R12: valid kicks keep reset released
    for (int k = 1; k <= 4; k++) expect_at(cyc + 30 * k, 0, 1'b1, "R12 valid kicks");
    wait_cyc(125);

    // R11: enable low with valid kicks changes nothing
    enable = 1'b0;
    expect_at(cyc + 20, 0, 1'b1, "R11 rst with enable low");
    expect_at(cyc + 60, 1, 1'b1, "R11 reg_on with enable low");
    wait_cyc(65);
    enable = 1'b1;

    // R7: short dip ignored
    in_reg = 1'b0;
    wait_cyc(UV_FILT - 1);
    in_reg = 1'b1;
    for (int k = 1; k <= 6; k++) expect_at(cyc + k, 0, 1'b1, "R7 glitch ignored");
    wait_cyc(10);

    // R7/R8: real dip
    m = cyc;
    in_reg = 1'b0;
    expect_at(m + UV_FILT, 0, 1'b1, "R7 before filter expiry");
    expect_at(m + UV_FILT + 1, 0, 1'b0, "R7 reset on dip");
    wait_cyc(10);
    m = cyc;
    in_reg = 1'b1;
    expect_at(m + POR_DLY, 0, 1'b0, "R8 held after dip");
    expect_at(m + POR_DLY + 1, 0, 1'b1, "R8 released after dip");
    wait_cyc(POR_DLY + 5);

    // R4: kicks stop -> pulse train
    kick_en = 1'b0;
    wait_fall(60, "R4 timeout fault");
    f = cyc;
    for (int k = 1; k <= 12; k++)
      expect_at(f + k, 0, logic'(((k / PULSE_W) % 2) == 1), "R5 pulse train");
    expect_at(f + 5, 1, 1'b1, "R5 reg_on during train");
    expect_at(f + 6, 2, 1'b0, "R5 no sleep during train");
    wait_cyc(13);

    // R6: recovery
    kick_en = 1'b1;
    wait_recover("R6 recovery after timeout");

    // R3: too-fast kicks
    kick_per = 4;
    wait_fall(60, "R3 early kick fault");
    expect_at(cyc + 1, 0, 1'b0, "R5 low phase after early fault");
    wait_cyc(3);
    kick_per = 16;
    wait_recover("R6 recovery after early fault");

    // R9: fault with enable low -> sleep
    enable = 1'b0;
    kick_en = 1'b0;
    for (int i = 0; i < 60 && !sleep; i++) @(negedge clk);
    rep(sleep == 1'b1, "R9 sleep entered", int'(sleep), 1);
    expect_at(cyc + 1, 1, 1'b0, "R9 regulator off");
    expect_at(cyc + 1, 0, 1'b0, "R9 reset low in sleep");
    wait_cyc(10);

    // R10: wake
    m = cyc;
    enable = 1'b1;
    kick_en = 1'b1;
    expect_at(m + 1, 2, 1'b0, "R10 sleep cleared");
    expect_at(m + 1, 1, 1'b1, "R10 regulator on");
    expect_at(m + POR_DLY + 1, 0, 1'b0, "R10 held for delay");
    expect_at(m + POR_DLY + 2, 0, 1'b1, "R10 released");
    wait_cyc(POR_DLY + 6);

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule